// File: doc/BRIEF.md
# Configurable Four-Requester Bus Arbiter

This block decides which of four requesters may drive a shared bus. Two of the requesters are write masters and two are read masters. Each has a fixed slot index: write master 1 is index 0, write master 0 is index 1, read master 1 is index 2 and read master 0 is index 3. A one-bit mode in the configuration register picks the arbitration policy. In rotating (round-robin) mode, the search for the next grant starts at the slot just after the one granted last. In fixed mode, each requester's 2-bit priority field decides the winner.

The grant is registered and one-hot. Once issued, it stays on the same requester until that requester pulses `bus_done`. The grant then drops for one cycle, and a fresh decision is made on the following clock edge. While `arb_en` is low, no grant is given, and the configuration register can be loaded through a plain write port. While `arb_en` is high, the register refuses writes, so the policy cannot change under a live arbitration.

Top module: `arb4_top`

## Requirements
- R1: After reset, `gnt` is 0, the mode is round-robin, every priority field is 0, and the first round-robin search starts at index 0.
- R2: While `arb_en` is 0, `gnt` is 0 after the next clock edge, including when a grant was active.
- R3: In round-robin mode (`cfg_wdata[8]`=0), the grant goes to the first requesting index found by searching upward, with wrap-around, from the index just after the last granted one.
- R4: An issued grant holds, whatever `req` does, until `bus_done` is high. It is then 0 for exactly one cycle, and a new decision takes effect on the following edge.
- R5: A configuration write (`cfg_we`=1) while `arb_en` is 1 is ignored and leaves the policy unchanged.
- R6: In fixed mode (`cfg_wdata[8]`=1), the requester with the smallest priority value wins. The priority of index i sits in `cfg_wdata[2i+1:2i]`, and 0 is the highest priority, 3 the lowest.
- R7: In fixed mode, among requesters with equal priority values, the lowest index wins.
- R8: In round-robin mode, the priority fields have no effect on the grant.
- R9: `gnt` is never more than one-hot, and a newly issued grant always goes to an index that was requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_en | input | 1 | Arbitration enable; also locks the configuration |
| req | input | 4 | Request per index (0=write1, 1=write0, 2=read1, 3=read0) |
| bus_done | input | 1 | Granted master finished its transfer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Bit 8 mode, bits [2i+1:2i] priority of index i |
| gnt | output | 4 | Registered one-hot grant |

## Verification
Round-robin is driven with all four requests, which shows whether the pointer rotates through every index. It is also driven with a sparse pattern (indices 0 and 3), which shows whether the search wraps and skips idle slots. Fixed mode is run with reversed priorities, to tell value ordering apart from index ordering. It is then run with all priorities equal, at both value 0 and value 3, which isolates the tie-break. Two further cases catch a policy that leaks into the wrong mode or a lock that fails. In the first, round-robin runs with priorities that would favour index 3. In the second, a write is attempted while the arbiter is enabled, and the grant order that follows is compared against the unchanged policy.

// File: rtl/arb4_pkg.sv
package arb4_pkg;

    parameter int unsigned ARB_N     = 4;
    parameter int unsigned ARB_PRI_W = 2;
    localparam int unsigned ARB_IDX_W = $clog2(ARB_N);
    localparam int unsigned ARB_CFG_W = ARB_N * ARB_PRI_W + 1;

    typedef enum logic {
        MODE_RR    = 1'b0,
        MODE_FIXED = 1'b1
    } arb_mode_e;

    // mode in the top bit, priority of index i in bits [2i+1:2i]
    typedef struct packed {
        arb_mode_e                             mode;
        logic [ARB_N-1:0][ARB_PRI_W-1:0]       pri;
    } arb_cfg_t;

endpackage

// File: rtl/arb4_cfg.sv
module arb4_cfg
    import arb4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     arb_en,
    input  logic     cfg_we,
    input  arb_cfg_t cfg_wdata,
    output arb_cfg_t cfg_o
);

    typedef struct packed {
        arb_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we && !arb_en) begin
            s_d.cfg = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        arb_en |=> $stable(s_q.cfg)); // R5

endmodule

// File: rtl/arb4_pick.sv
module arb4_pick
    import arb4_pkg::*;
(
    input  logic [ARB_N-1:0]     req,
    input  arb_cfg_t             cfg,
    input  logic [ARB_IDX_W-1:0] last_idx,
    output logic [ARB_N-1:0]     pick_oh,
    output logic [ARB_IDX_W-1:0] pick_idx
);

    logic [ARB_N-1:0]     rr_oh;
    logic [ARB_IDX_W-1:0] rr_idx;
    logic                 rr_found;

    logic [ARB_N-1:0]     fx_oh;
    logic [ARB_IDX_W-1:0] fx_idx;
    logic [ARB_PRI_W-1:0] fx_best;
    logic                 fx_found;

    // rotating search starting after the last granted slot
    always_comb begin
        logic [ARB_IDX_W-1:0] probe;
        rr_oh    = '0;
        rr_idx   = '0;
        rr_found = 1'b0;
        for (int k = 1; k <= ARB_N; k++) begin
            probe = ARB_IDX_W'((int'(last_idx) + k) % ARB_N);
            if (!rr_found && req[probe]) begin
                rr_found      = 1'b1;
                rr_idx        = probe;
                rr_oh[probe]  = 1'b1;
            end
        end
    end

    // smallest priority value wins; strict compare keeps the lower index on ties
    always_comb begin
        fx_oh    = '0;
        fx_idx   = '0;
        fx_best  = '1;
        fx_found = 1'b0;
        for (int i = 0; i < ARB_N; i++) begin
            if (req[i] && (!fx_found || cfg.pri[i] < fx_best)) begin
                fx_found = 1'b1;
                fx_best  = cfg.pri[i];
                fx_idx   = ARB_IDX_W'(i);
            end
        end
        if (fx_found) begin
            fx_oh[fx_idx] = 1'b1;
        end
    end

    always_comb begin
        if (cfg.mode == MODE_FIXED) begin
            pick_oh  = fx_oh;
            pick_idx = fx_idx;
        end else begin
            pick_oh  = rr_oh;
            pick_idx = rr_idx;
        end
    end

endmodule

// File: rtl/arb4_top.sv
module arb4_top
    import arb4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arb_en,
    input  logic [ARB_N-1:0]     req,
    input  logic                 bus_done,
    input  logic                 cfg_we,
    input  logic [ARB_CFG_W-1:0] cfg_wdata,
    output logic [ARB_N-1:0]     gnt
);

    typedef struct packed {
        logic [ARB_N-1:0]     gnt;
        logic [ARB_IDX_W-1:0] last;
    } arb_state_t;

    arb_state_t           s_d, s_q;
    arb_cfg_t             cfg;
    logic [ARB_N-1:0]     pick_oh;
    logic [ARB_IDX_W-1:0] pick_idx;

    arb4_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_en    (arb_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (arb_cfg_t'(cfg_wdata)),
        .cfg_o     (cfg)
    );

    arb4_pick u_pick (
        .req      (req),
        .cfg      (cfg),
        .last_idx (s_q.last),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    always_comb begin
        s_d = s_q;
        if (!arb_en) begin
            s_d.gnt = '0;
        end else if (s_q.gnt != '0) begin
            if (bus_done) begin
                s_d.gnt = '0;
            end
        end else if (pick_oh != '0) begin
            s_d.gnt  = pick_oh;
            s_d.last = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.gnt  <= '0;
            s_q.last <= ARB_IDX_W'(ARB_N - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt = s_q.gnt;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R9
    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> (gnt == '0 || (gnt & $past(req)) != '0)); // R9
    AST_NO_GNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (gnt == '0)); // R2
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && gnt != '0 && !bus_done) |=> (gnt == $past(gnt))); // R4
    AST_GNT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && bus_done) |=> (gnt == '0)); // R4

endmodule

// File: tb/sim_arb4_top.sv
module sim_arb4_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       arb_en;
    logic [3:0] req;
    logic       bus_done;
    logic       cfg_we;
    logic [8:0] cfg_wdata;
    logic [3:0] gnt;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    arb4_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_en    (arb_en),
        .req       (req),
        .bus_done  (bus_done),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .gnt       (gnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        checks++;
        if (gnt !== exp) begin
            fails++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    // one grant cycle: expect exp, release with bus_done, expect idle gap
    task automatic serve(input string tag, input logic [3:0] exp);
        tick();
        chk(tag, exp);
        bus_done = 1'b1;
        tick();
        chk({tag, " gap"}, 4'b0000);
        bus_done = 1'b0;
    endtask

    task automatic write_cfg(input logic [8:0] val);
        cfg_we    = 1'b1;
        cfg_wdata = val;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset idle", 4'b0000);
    endtask

    task automatic t_disabled();
        arb_en = 1'b0;
        req    = 4'b1111;
        tick();
        tick();
        chk("R2 disabled", 4'b0000);
    endtask

    task automatic t_round_robin();
        arb_en = 1'b1;
        req    = 4'b1111;
        serve("R1 first from index0", 4'b0001);
        serve("R3 rotate 1", 4'b0010);
        serve("R3 rotate 2", 4'b0100);
        serve("R3 rotate 3", 4'b1000);
        serve("R3 wrap", 4'b0001);
        req = 4'b1001;
        serve("R3 skip idle", 4'b1000);
        serve("R3 sparse wrap", 4'b0001);
    endtask

    task automatic t_locked_write();
        req = 4'b0000;
        write_cfg(9'h11B);
        req = 4'b1111;
        serve("R5 write ignored", 4'b0010);
        serve("R5 still rotating", 4'b0100);
    endtask

    task automatic t_fixed();
        arb_en = 1'b0;
        write_cfg(9'h11B);
        arb_en = 1'b1;
        req    = 4'b1111;
        serve("R6 best value", 4'b1000);
        serve("R6 best again", 4'b1000);
        req = 4'b0111;
        serve("R6 next best", 4'b0100);
        req = 4'b0011;
        serve("R6 value over index", 4'b0010);
    endtask

    task automatic t_ties();
        arb_en = 1'b0;
        write_cfg(9'h100);
        arb_en = 1'b1;
        req    = 4'b1110;
        serve("R7 tie low index", 4'b0010);
        req = 4'b1111;
        serve("R7 tie index0", 4'b0001);
        arb_en = 1'b0;
        write_cfg(9'h1FF);
        arb_en = 1'b1;
        req    = 4'b1100;
        serve("R7 tie at lowest prio", 4'b0100);
    endtask

    task automatic t_rr_ignores_pri();
        arb_en = 1'b0;
        write_cfg(9'h01B);
        arb_en = 1'b1;
        req    = 4'b1111;
        serve("R8 rr a", 4'b1000);
        serve("R8 rr b", 4'b0001);
        serve("R8 rr c", 4'b0010);
        serve("R8 rr d", 4'b0100);
    endtask

    task automatic t_hold();
        req = 4'b1111;
        tick();
        chk("R4 granted", 4'b1000);
        for (int i = 0; i < 4; i++) begin
            if (i == 2) req = 4'b0001;
            tick();
            chk("R4 hold", 4'b1000);
        end
        bus_done = 1'b1;
        tick();
        chk("R4 release gap", 4'b0000);
        bus_done = 1'b0;
        tick();
        chk("R4 rearbitrate", 4'b0001);
        arb_en = 1'b0;
        tick();
        chk("R2 drop on disable", 4'b0000);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        arb_en    = 1'b0;
        req       = 4'b0000;
        bus_done  = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = 9'h000;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_round_robin();
        t_locked_write();
        t_fixed();
        t_ties();
        t_rr_ignores_pri();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule